// File: doc/BRIEF.md
# Coherent Time Reader with Rollover Retry

This block sits on the host side of a real-time clock and builds one consistent time value from a device that only supports single-register reads. On a start pulse it reads the seconds register, then the six higher timekeeping registers, then seconds a second time. It then compares the two seconds readings. A seconds carry can land between the first read and the reads of the higher fields. If it does, the block throws the pass away and runs the whole sequence again. Otherwise it publishes the seven assembled bytes together with a one-cycle completion pulse.

Reads go out over a request/response port that a bus adapter serves. A request carries a register index and uses valid/ready. The block holds `req_valid` and `req_idx` steady until `req_ready` is seen high at a clock edge. Only one read is outstanding at a time. The response also uses valid/ready. `rsp_ready` is high only while the block is waiting for the data of an accepted request, and the data is taken in the cycle where `rsp_valid` and `rsp_ready` are both high. The adapter may stall either side for any number of cycles.

The block also checks how far apart the two seconds readings are. A forward distance of more than one second means the reads took too long, and `skew_err` pulses. A parameter limits how many times a pass may be restarted. When one more restart would be needed after that limit is reached, the block gives up and pulses `fail`.

Top module: `tk_coherent_reader`

## Requirements
- R1: After reset, `busy`, `req_valid`, `rsp_ready`, `done`, `fail` and `skew_err` are low, and `time_out` is all zero.
- R2: A `start` pulse while idle begins a pass. The pass issues exactly eight reads, in the index order 0,1,2,3,4,5,6,0. The index codes are: seconds = 0, minutes = 1, hours = 2, date = 3, month = 4, day = 5, year = 6.
- R3: While `req_ready` is low, a raised request keeps `req_valid` high and `req_idx` unchanged. `req_valid` and `rsp_ready` are never high together, so at most one read is outstanding.
- R4: A pass whose first seconds value is not 0x59, or whose second value is 0x59, ends with a one-cycle `done` pulse. In that same cycle `time_out` holds the first seconds value in bits 7:0 and the register with index k in bits 8k+7:8k, for k = 1 to 6.
- R5: If the first seconds value is 0x59 and the second is not 0x59, the pass is discarded and a new pass starts at once with index 0, with no `start`. `time_out` does not change and no `done` is given for the discarded pass.
- R6: At most MAX_RETRY restarts (default 3) follow one `start`. If another restart would be needed, `fail` pulses for one cycle instead, `done` stays low, `time_out` is unchanged and the block returns to idle.
- R7: At the end of every pass, whether it publishes, restarts or fails, `skew_err` pulses for one cycle when the forward distance from the first to the second seconds value, counted modulo 60 on the BCD values, is greater than 1. The pulse falls in the same cycle as that pass's `done` or `fail`, when there is one.
- R8: `time_out` changes only in a cycle where `done` is high.
- R9: A `start` pulse is ignored while `busy` is high.
- R10: Each accepted `start` gives a fresh budget of MAX_RETRY restarts, even after a `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read sequence when idle |
| busy | output | 1 | A sequence is in progress |
| req_valid | output | 1 | Read request is presented |
| req_ready | input | 1 | Adapter accepts the request |
| req_idx | output | 3 | Register index of the request |
| rsp_valid | input | 1 | Read data is presented |
| rsp_ready | output | 1 | Block is waiting for read data |
| rsp_data | input | 8 | Register contents (BCD) |
| done | output | 1 | One-cycle pulse: new coherent time published |
| fail | output | 1 | One-cycle pulse: restart budget exhausted |
| skew_err | output | 1 | One-cycle pulse: seconds readings more than 1 s apart |
| time_out | output | 56 | Last published time, seven bytes, seconds in the low byte |

## Verification
The completion pulse and the skew flag are separate pieces of logic, yet both are decided at the end of a pass and can fall in the same cycle. The bench provokes this with seconds pairs such as 0x30/0x33 and 0x05/0x04 (a wrap modulo 60). It records the cycle number of every `done` and `skew_err` pulse and requires the two to match. The same coincidence with `fail` is forced by feeding 0x59/0x01 on every pass until the restart budget runs out. The bench then requires four skew pulses, one `fail` in the cycle of the last of them, and no `done`.

// File: rtl/tkr_pkg.sv
package tkr_pkg;
  localparam int NREG = 7;                 // timekeeping registers per snapshot
  localparam int DW   = 8;                 // register width
  localparam int IW   = $clog2(NREG);      // index width
  localparam int SW   = $clog2(NREG + 1);  // step counter width (includes re-read)
  localparam int TW   = NREG * DW;         // assembled time width
  localparam int SEC_MOD = 60;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_AWAIT = 2'd2,
    S_JUDGE = 2'd3
  } tkr_state_e;

  function automatic int bcd_to_int(input logic [DW-1:0] b);
    return int'(b[6:4]) * 10 + int'(b[3:0]);
  endfunction

  // forward distance from a to b, modulo one minute
  function automatic logic [5:0] sec_gap(input logic [DW-1:0] a, input logic [DW-1:0] b);
    int g;
    g = bcd_to_int(b) - bcd_to_int(a);
    if (g < 0) g = g + SEC_MOD;
    return g[5:0];
  endfunction
endpackage

// File: rtl/tkr_seq.sv
module tkr_seq
  import tkr_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          retry_need,
  output logic          busy,
  output logic          req_valid,
  output logic [IW-1:0] req_idx,
  output logic          rsp_ready,
  output logic          cap_en,
  output logic [SW-1:0] cap_step,
  output logic          judge,
  output logic          commit,
  output logic          done,
  output logic          fail
);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [SW-1:0] LAST  = SW'(NREG);
  localparam logic [RW-1:0] RLIM  = RW'(MAX_RETRY);

  tkr_state_e    state;
  logic [SW-1:0] step;
  logic [RW-1:0] rcnt;

  assign busy      = (state != S_IDLE);
  assign req_valid = (state == S_ISSUE);
  assign rsp_ready = (state == S_AWAIT);
  assign req_idx   = (step == LAST) ? '0 : step[IW-1:0];
  assign cap_en    = rsp_ready && rsp_valid;
  assign cap_step  = step;
  assign judge     = (state == S_JUDGE);
  assign commit    = judge && !retry_need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
      rcnt  <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            rcnt  <= '0;
            step  <= '0;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (req_ready) state <= S_AWAIT;
        end
        S_AWAIT: begin
          if (rsp_valid) begin
            if (step == LAST) begin
              state <= S_JUDGE;
            end else begin
              step  <= step + 1'b1;
              state <= S_ISSUE;
            end
          end
        end
        S_JUDGE: begin
          if (retry_need) begin
            if (rcnt == RLIM) begin
              fail  <= 1'b1;
              state <= S_IDLE;
            end else begin
              rcnt  <= rcnt + 1'b1;
              step  <= '0;
              state <= S_ISSUE;
            end
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tkr_capture.sv
module tkr_capture
  import tkr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [SW-1:0] cap_step,
  input  logic [DW-1:0] rsp_data,
  input  logic          commit,
  output logic [DW-1:0] ini_sec,
  output logic [DW-1:0] fin_sec,
  output logic [TW-1:0] time_out
);
  logic [TW-1:0] snap;

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) byte_q <= '0;
      else if (cap_en && (cap_step == SW'(i))) byte_q <= rsp_data;
    end
    assign snap[i*DW +: DW] = byte_q;
  end

  assign ini_sec = snap[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_sec  <= '0;
      time_out <= '0;
    end else begin
      if (cap_en && (cap_step == SW'(NREG))) fin_sec <= rsp_data;
      if (commit) time_out <= snap;
    end
  end
endmodule

// File: rtl/tkr_judge.sv
module tkr_judge
  import tkr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          judge,
  input  logic [DW-1:0] ini_sec,
  input  logic [DW-1:0] fin_sec,
  output logic          retry_need,
  output logic          skew_err
);
  localparam logic [DW-1:0] SEC_TOP = 8'h59;
  logic [5:0] gap;

  assign retry_need = (ini_sec == SEC_TOP) && (fin_sec != SEC_TOP);
  assign gap        = sec_gap(ini_sec, fin_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) skew_err <= 1'b0;
    else        skew_err <= judge && (gap > 6'd1);
  end
endmodule

// File: rtl/tk_coherent_reader.sv
module tk_coherent_reader
  import tkr_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [IW-1:0] req_idx,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          done,
  output logic          fail,
  output logic          skew_err,
  output logic [TW-1:0] time_out
);
  logic          retry_need, cap_en, judge, commit;
  logic [SW-1:0] cap_step;
  logic [DW-1:0] ini_sec, fin_sec;

  tkr_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .retry_need(retry_need), .busy(busy),
    .req_valid(req_valid), .req_idx(req_idx), .rsp_ready(rsp_ready),
    .cap_en(cap_en), .cap_step(cap_step), .judge(judge), .commit(commit),
    .done(done), .fail(fail)
  );

  tkr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_step(cap_step),
    .rsp_data(rsp_data), .commit(commit), .ini_sec(ini_sec),
    .fin_sec(fin_sec), .time_out(time_out)
  );

  tkr_judge u_judge (
    .clk(clk), .rst_n(rst_n), .judge(judge), .ini_sec(ini_sec),
    .fin_sec(fin_sec), .retry_need(retry_need), .skew_err(skew_err)
  );
endmodule

// File: rtl/tkr_sva.sv
module tkr_sva
  import tkr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic [IW-1:0] req_idx,
  input logic          rsp_ready,
  input logic          done,
  input logic          fail,
  input logic [TW-1:0] time_out
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_idx));

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_idx) < NREG));

  p_done_fail_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  p_time_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(time_out));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_ready);

  p_fail_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy);
endmodule

bind tk_coherent_reader tkr_sva u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_idx(req_idx), .rsp_ready(rsp_ready),
  .done(done), .fail(fail), .time_out(time_out)
);

// File: tb/tk_coherent_reader_tb.sv
module tk_coherent_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, req_valid, rsp_ready, done, fail, skew_err;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [2:0]  req_idx;
  logic [7:0]  rsp_data = 8'h00;
  logic [55:0] time_out;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int n_req = 0, n_done = 0, n_fail = 0, n_skew = 0;
  int done_cyc = -1, skew_cyc = -1, fail_cyc = -1;
  int log_idx [0:63];
  logic [7:0] sec_list [0:15];
  int sec_ptr = 0;
  logic [7:0] regs_a [1:6];
  logic [7:0] regs_b [1:6];
  bit stall = 0;

  always #5 clk = ~clk;

  tk_coherent_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done(done), .fail(fail), .skew_err(skew_err), .time_out(time_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done)     begin n_done++; done_cyc = cyc; end
      if (fail)     begin n_fail++; fail_cyc = cyc; end
      if (skew_err) begin n_skew++; skew_cyc = cyc; end
    end
  end

  // bus adapter model
  initial begin
    bit pend = 0;
    int lat = 0;
    bit tog = 0;
    logic [7:0] dat;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        rsp_valid = 1'b0;
      end else if (pend) begin
        req_ready = 1'b0;
        if (lat > 0) lat--;
        else begin rsp_valid = 1'b1; rsp_data = dat; pend = 0; end
      end else begin
        tog = ~tog;
        req_ready = stall ? tog : 1'b1;
        if (req_ready && req_valid) begin
          if (n_req < 64) log_idx[n_req] = int'(req_idx);
          n_req++;
          if (req_idx == 3'd0) begin
            dat = sec_list[sec_ptr % 16];
            sec_ptr++;
          end else if (req_idx <= 3'd6) begin
            dat = (sec_ptr >= 2) ? regs_b[int'(req_idx)] : regs_a[int'(req_idx)];
          end else dat = 8'hEE;
          pend = 1;
          lat = stall ? 2 : 0;
        end
      end
    end
  end

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=finished)");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] build(input logic [7:0] sec, input bit use_b);
    logic [55:0] t;
    t[7:0] = sec;
    for (int k = 1; k <= 6; k++) t[k*8 +: 8] = use_b ? regs_b[k] : regs_a[k];
    return t;
  endfunction

  task automatic set_regs(input logic [7:0] base, input logic [7:0] base_b);
    for (int k = 1; k <= 6; k++) begin
      regs_a[k] = base + 8'(k);
      regs_b[k] = base_b + 8'(k);
    end
  endtask

  task automatic kick(input bit poke_busy);
    n_req = 0; n_done = 0; n_fail = 0; n_skew = 0; sec_ptr = 0;
    done_cyc = -1; skew_cyc = -1; fail_cyc = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < 3000 && busy; w++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic bit order_ok(input int n);
    for (int i = 0; i < n && i < 64; i++)
      if (log_idx[i] != ((i % 8 == 7) ? 0 : (i % 8))) return 0;
    return 1;
  endfunction

  task automatic t_reset;
    chk(!busy && !req_valid && !rsp_ready, "R1 idle outputs", {busy, req_valid, rsp_ready}, 0);
    chk(!done && !fail && !skew_err, "R1 pulses low", {done, fail, skew_err}, 0);
    chk(time_out == 56'h0, "R1 time_out zero", time_out, 0);
  endtask

  task automatic t_basic;
    set_regs(8'h10, 8'h10);
    sec_list[0] = 8'h12; sec_list[1] = 8'h12;
    kick(0);
    chk(n_req == 8, "R2 read count", n_req, 8);
    chk(order_ok(8), "R2 index order", log_idx[7], 0);
    chk(n_done == 1, "R4 done pulse", n_done, 1);
    chk(time_out == build(8'h12, 0), "R4 assembled time", time_out, build(8'h12, 0));
    chk(n_skew == 0, "R7 no skew", n_skew, 0);
  endtask

  task automatic t_stall_top;
    stall = 1;
    set_regs(8'h20, 8'h20);
    sec_list[0] = 8'h59; sec_list[1] = 8'h59;
    kick(0);
    stall = 0;
    chk(n_req == 8 && order_ok(8), "R3 order under stalls", n_req, 8);
    chk(n_done == 1, "R4 59/59 publishes", n_done, 1);
    chk(time_out == build(8'h59, 0), "R4 time after stalls", time_out, build(8'h59, 0));
  endtask

  task automatic t_rollover;
    set_regs(8'h30, 8'h40);
    sec_list[0] = 8'h59; sec_list[1] = 8'h00;
    sec_list[2] = 8'h00; sec_list[3] = 8'h00;
    kick(0);
    chk(n_req == 16 && order_ok(16), "R5 restart reads", n_req, 16);
    chk(n_done == 1, "R5 single done", n_done, 1);
    chk(time_out == build(8'h00, 1), "R5 second pass data", time_out, build(8'h00, 1));
    chk(n_skew == 0, "R7 59->00 is one second", n_skew, 0);
  endtask

  task automatic t_skew;
    set_regs(8'h50, 8'h50);
    sec_list[0] = 8'h30; sec_list[1] = 8'h33;
    kick(0);
    chk(n_skew == 1 && n_done == 1, "R7 skew with done", n_skew, 1);
    chk(skew_cyc == done_cyc, "R7 same cycle", skew_cyc, done_cyc);
    sec_list[0] = 8'h05; sec_list[1] = 8'h04;
    kick(0);
    chk(n_skew == 1 && skew_cyc == done_cyc, "R7 backward gap wraps", n_skew, 1);
    chk(time_out == build(8'h05, 0), "R4 time with skew", time_out, build(8'h05, 0));
  endtask

  task automatic t_fail;
    logic [55:0] keep;
    keep = time_out;
    set_regs(8'h60, 8'h70);
    for (int i = 0; i < 16; i += 2) begin sec_list[i] = 8'h59; sec_list[i+1] = 8'h01; end
    kick(0);
    chk(n_req == 32, "R6 four passes", n_req, 32);
    chk(n_fail == 1 && n_done == 0, "R6 fail no done", n_fail, 1);
    chk(time_out == keep, "R8 time held on fail", time_out, keep);
    chk(n_skew == 4 && skew_cyc == fail_cyc, "R7 skew on every pass", n_skew, 4);
    chk(!busy, "R6 back to idle", busy, 0);
  endtask

  task automatic t_fresh_budget;
    set_regs(8'h01, 8'h11);
    sec_list[0] = 8'h59; sec_list[1] = 8'h00;
    sec_list[2] = 8'h59; sec_list[3] = 8'h02;
    sec_list[4] = 8'h59; sec_list[5] = 8'h59;
    kick(0);
    chk(n_req == 24 && n_fail == 0, "R10 fresh retries", n_req, 24);
    chk(n_done == 1 && time_out == build(8'h59, 1), "R10 publish after retries", time_out, build(8'h59, 1));
  endtask

  task automatic t_busy_start;
    set_regs(8'h02, 8'h02);
    sec_list[0] = 8'h44; sec_list[1] = 8'h45;
    kick(1);
    repeat (20) @(negedge clk);
    chk(n_req == 8, "R9 start while busy ignored", n_req, 8);
    chk(n_done == 1, "R9 single done", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall_top();
    t_rollover();
    t_skew();
    t_fail();
    t_fresh_budget();
    t_busy_start();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule